// File: doc/BRIEF.md
# Card Data FIFO Transfer Engine

This block sits between a host register port and a byte-wide card data port. It carries 32-bit words between the two sides through a 16-word circular FIFO. The host writes a byte count into a length register, then writes the control register with the enable bit set and a direction bit. In the card-to-host direction the engine takes one card byte per cycle and packs the bytes into words, which the host pops from a FIFO window. In the host-to-card direction the host pushes words into the FIFO window and the engine sends them to the card one byte per cycle.

The engine keeps a count of the bytes still to move. It raises sticky end-of-transfer flags when that count reaches zero and turns itself off once the FIFO has also drained. It reports FIFO occupancy through a status word whose flag group depends on the direction. After the host pops a word, the engine holds off further card reads until the host polls the status or word-count register. This matches a software driver that must not see new data arrive while it is draining the FIFO.

Top module: `card_fifo_engine`

## Requirements
- R1: After reset, the status, control and remaining-count registers read 0, a read of the FIFO window returns 0, and neither card strobe (card_rd_take, card_wr_valid) is asserted.
- R2: The register map is: host_addr 0 = length, 1 = control, 2 = remaining count, 3 = word count, 4 = status, 5 = clear, 6 = FIFO window. The length register keeps only the low 16 bits of a write. In the control register, bit 0 is enable and bit 1 is direction (1 = card to host), and it reads back those two bits. A control write with bit 0 set loads the remaining count from the length register.
- R3: In the card-to-host direction the engine takes at most one byte per cycle (card_rd_take high), and only while card_rd_ready is high, the hold-off flag is clear, the remaining count is nonzero and the FIFO is not full. Bytes are packed least significant first. A word is pushed after every fourth byte, and after the last byte with zero upper bytes.
- R4: The FIFO holds 16 words. A card-to-host transfer longer than 64 bytes stops with the FIFO full until the host pops words.
- R5: In the host-to-card direction the engine pops a word and presents its bytes lowest first on card_wr_data, one per cycle with card_wr_valid high. It sends exactly as many bytes as the remaining count and decrements that count once per byte. In a cycle in which the host accesses the FIFO window, the engine moves no byte.
- R6: While the engine is enabled and the remaining count is zero, status bit 0 (data end) and bit 1 (block end) are set. Both stay set until a write to the clear register with 1 in the matching bit position. A zero length sets them straight away.
- R7: When the engine is enabled and both the remaining count and the FIFO level are zero, the enable bit clears itself. The direction bit is kept.
- R8: Status bits 2 to 11 are FIFO flags. Bit 2+2f+g holds field f of group g, where g = 0 is transmit and g = 1 is receive. The fields are f = 0 active, 1 half (transmit: level ≤ 8, receive: level ≥ 8), 2 full (level 16), 3 empty (level 0) and 4 data available (level > 0). Only the receive group is shown in the card-to-host direction and only the transmit group otherwise. All of these flags are 0 unless the engine is enabled and the count and level are not both zero.
- R9: A host read of the FIFO window that pops a word sets a hold-off flag that stops card-to-host transfers. A read of the status register or the word-count register clears it.
- R10: The word-count register reads (remaining count + 3) >> 2.
- R11: A FIFO window read with the FIFO empty returns 0 and pops nothing. A FIFO window write while the remaining count is 0 is ignored.
- R12: A push into a full FIFO is dropped, and a pop of an empty FIFO leaves the FIFO unchanged. Words written while the FIFO is full never reach the card.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (read side effects apply at the clock edge) |
| host_addr | input | 3 | Register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr, valid in the same cycle |
| card_rd_ready | input | 1 | Card has a byte available on card_rd_data |
| card_rd_data | input | 8 | Byte from the card |
| card_rd_take | output | 1 | Engine consumes card_rd_data at this clock edge |
| card_wr_valid | output | 1 | card_wr_data carries a byte for the card this cycle |
| card_wr_data | output | 8 | Byte to the card |

## Verification
If the pack index or the unpack byte counter is wrong, a byte lands in the wrong lane of a FIFO word, or the card receives the wrong byte. Both show up on the first word of a transfer. If the remaining count is wrong, the number of card strobes changes, and the remaining-count and word-count registers show it a few cycles after the transfer settles. Faults in the FIFO pointers or level show as wrong words or wrong status flags once the FIFO fills past half or wraps, which the 80-byte transfers do within about a hundred cycles. A hold-off flag stuck either way shows as a remaining count that keeps falling, or never falls, after a FIFO pop.

// File: rtl/cfe_pkg.sv
package cfe_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_LEN    = 3'd0,
        A_CTRL   = 3'd1,
        A_REMAIN = 3'd2,
        A_WORDS  = 3'd3,
        A_STATUS = 3'd4,
        A_CLEAR  = 3'd5,
        A_FIFO   = 3'd6,
        A_SPARE  = 3'd7
    } cfe_addr_e;

    // status layout: two sticky end bits, then FIFO flags interleaved tx/rx
    localparam int ST_DATA_END  = 0;
    localparam int ST_BLOCK_END = 1;
    localparam int ST_FIFO_LSB  = 2;

    localparam int FG_ACTIVE = 0;
    localparam int FG_HALF   = 1;
    localparam int FG_FULL   = 2;
    localparam int FG_EMPTY  = 3;
    localparam int FG_AVAIL  = 4;
    localparam int FG_N      = 5;

    localparam int STAT_W = ST_FIFO_LSB + 2 * FG_N;

endpackage

// File: rtl/cfe_fifo.sv
module cfe_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [WIDTH-1:0]           push_data,
    input  logic                       pop,
    output logic [WIDTH-1:0]           head,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    // DEPTH must be a power of two: write index wraps by truncation
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] rd_ptr;
        logic [LVL_W-1:0] level;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;
    logic [PTR_W-1:0] wr_idx;

    assign push_ok = push && (st_q.level < LVL_W'(DEPTH));
    assign pop_ok  = pop && (st_q.level != '0);
    assign wr_idx  = st_q.rd_ptr + st_q.level[PTR_W-1:0];
    assign head    = mem_q[st_q.rd_ptr];
    assign level   = st_q.level;

    always_comb begin
        st_d = st_q;
        if (pop_ok) begin
            st_d.rd_ptr = st_q.rd_ptr + 1'b1;
        end
        if (push_ok && !pop_ok) begin
            st_d.level = st_q.level + 1'b1;
        end else if (pop_ok && !push_ok) begin
            st_d.level = st_q.level - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_q[wr_idx] <= push_data;
        end
    end

    // R12: a push into a full FIFO changes nothing
    p_full_push_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && st_q.level == LVL_W'(DEPTH))
        |=> (st_q.level == LVL_W'(DEPTH)) && $stable(st_q.rd_ptr));

    // R12: a pop of an empty FIFO changes nothing
    p_empty_pop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && st_q.level == '0)
        |=> (st_q.level == '0) && $stable(st_q.rd_ptr));

    // R4: level never passes the depth
    p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.level <= LVL_W'(DEPTH));

endmodule

// File: rtl/cfe_flags.sv
module cfe_flags
    import cfe_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5
) (
    input  logic [LVL_W-1:0]  level,
    input  logic              active,
    input  logic              dir_rx,
    output logic [2*FG_N-1:0] flags
);
    for (genvar g = 0; g < 2; g++) begin : g_grp
        logic shown;
        logic half;
        assign shown = active && (dir_rx == (g == 1));
        if (g == 0) begin : g_tx
            assign half = level <= LVL_W'(DEPTH / 2);
        end else begin : g_rx
            assign half = level >= LVL_W'(DEPTH / 2);
        end
        assign flags[2*FG_ACTIVE + g] = shown;
        assign flags[2*FG_HALF   + g] = shown && half;
        assign flags[2*FG_FULL   + g] = shown && (level == LVL_W'(DEPTH));
        assign flags[2*FG_EMPTY  + g] = shown && (level == '0);
        assign flags[2*FG_AVAIL  + g] = shown && (level != '0);
    end

endmodule

// File: rtl/card_fifo_engine.sv
module card_fifo_engine
    import cfe_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int WORD_BYTES = 4,
    parameter int LEN_W      = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_wr,
    input  logic                  host_rd,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic [8*WORD_BYTES-1:0] host_wdata,
    output logic [8*WORD_BYTES-1:0] host_rdata,
    input  logic                  card_rd_ready,
    input  logic [7:0]            card_rd_data,
    output logic                  card_rd_take,
    output logic                  card_wr_valid,
    output logic [7:0]            card_wr_data
);
    localparam int WORD_W = 8 * WORD_BYTES;
    localparam int LVL_W  = $clog2(FIFO_DEPTH + 1);
    localparam int IDX_W  = $clog2(WORD_BYTES);

    typedef struct packed {
        logic              en;
        logic              dir_rx;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  rem;
        logic              hold;
        logic              data_end;
        logic              block_end;
        logic [WORD_W-1:0] pack;
        logic [IDX_W-1:0]  pack_idx;
        logic [WORD_W-1:0] unpack;
        logic [IDX_W-1:0]  unpack_left;
    } eng_t;

    eng_t s_d, s_q;

    cfe_addr_e         addr;
    logic              len_wr, ctrl_wr, clear_wr;
    logic              host_fifo_rd, host_fifo_wr, host_touch;
    logic              host_pop, host_push, hold_release;
    logic              rx_step, rx_push, tx_step, tx_pop;
    logic              fifo_push, fifo_pop;
    logic [WORD_W-1:0] fifo_wdata, fifo_head, packed_word;
    logic [LVL_W-1:0]  fifo_level;
    logic              fifo_full;
    logic              flags_active;
    logic [2*FG_N-1:0] fifo_flags;
    logic [STAT_W-1:0] status_word;
    logic [LEN_W:0]    words_sum;

    assign addr         = cfe_addr_e'(host_addr);
    assign len_wr       = host_wr && (addr == A_LEN);
    assign ctrl_wr      = host_wr && (addr == A_CTRL);
    assign clear_wr     = host_wr && (addr == A_CLEAR);
    assign host_fifo_rd = host_rd && (addr == A_FIFO);
    assign host_fifo_wr = host_wr && (addr == A_FIFO);
    assign host_touch   = host_fifo_rd || host_fifo_wr;
    assign host_pop     = host_fifo_rd && (fifo_level != '0);
    assign host_push    = host_fifo_wr && (s_q.rem != '0);
    assign hold_release = host_rd && ((addr == A_STATUS) || (addr == A_WORDS));
    assign fifo_full    = (fifo_level == LVL_W'(FIFO_DEPTH));

    // card-to-host: one byte per cycle into the packing register
    assign rx_step = s_q.en && s_q.dir_rx && (s_q.rem != '0) && card_rd_ready
                     && !s_q.hold && !host_touch && !fifo_full;
    assign rx_push = rx_step && ((s_q.pack_idx == IDX_W'(WORD_BYTES - 1))
                                 || (s_q.rem == LEN_W'(1)));
    assign packed_word = s_q.pack
                       | (WORD_W'(card_rd_data) << {s_q.pack_idx, 3'b000});

    // host-to-card: one byte per cycle out of the unpacking register
    assign tx_step = s_q.en && !s_q.dir_rx && (s_q.rem != '0) && !host_touch
                     && ((s_q.unpack_left != '0) || (fifo_level != '0));
    assign tx_pop  = tx_step && (s_q.unpack_left == '0);

    assign fifo_push  = host_push || rx_push;
    assign fifo_pop   = host_pop || tx_pop;
    assign fifo_wdata = host_push ? host_wdata : packed_word;

    assign card_rd_take  = rx_step;
    assign card_wr_valid = tx_step;
    assign card_wr_data  = (s_q.unpack_left == '0) ? fifo_head[7:0]
                                                   : s_q.unpack[7:0];

    cfe_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (WORD_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (fifo_wdata),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .level     (fifo_level)
    );

    assign flags_active = s_q.en && !((s_q.rem == '0) && (fifo_level == '0));

    cfe_flags #(
        .DEPTH (FIFO_DEPTH),
        .LVL_W (LVL_W)
    ) u_flags (
        .level  (fifo_level),
        .active (flags_active),
        .dir_rx (s_q.dir_rx),
        .flags  (fifo_flags)
    );

    assign status_word = {fifo_flags, s_q.block_end, s_q.data_end};
    assign words_sum   = {1'b0, s_q.rem} + (LEN_W + 1)'(WORD_BYTES - 1);

    always_comb begin
        s_d = s_q;

        if (rx_step) begin
            s_d.rem = s_q.rem - 1'b1;
            if (rx_push) begin
                s_d.pack     = '0;
                s_d.pack_idx = '0;
            end else begin
                s_d.pack     = packed_word;
                s_d.pack_idx = s_q.pack_idx + 1'b1;
            end
        end

        if (tx_step) begin
            s_d.rem = s_q.rem - 1'b1;
            if (tx_pop) begin
                s_d.unpack      = fifo_head >> 8;
                s_d.unpack_left = IDX_W'(WORD_BYTES - 1);
            end else begin
                s_d.unpack      = s_q.unpack >> 8;
                s_d.unpack_left = s_q.unpack_left - 1'b1;
            end
        end

        if (host_pop) begin
            s_d.hold = 1'b1;
        end
        if (hold_release) begin
            s_d.hold = 1'b0;
        end

        if (clear_wr) begin
            s_d.data_end  = s_q.data_end  & ~host_wdata[ST_DATA_END];
            s_d.block_end = s_q.block_end & ~host_wdata[ST_BLOCK_END];
        end
        if (s_q.en && (s_q.rem == '0)) begin
            s_d.data_end  = 1'b1;
            s_d.block_end = 1'b1;
            if (fifo_level == '0) begin
                s_d.en = 1'b0;
            end
        end

        if (len_wr) begin
            s_d.len = host_wdata[LEN_W-1:0];
        end
        if (ctrl_wr) begin
            s_d.en     = host_wdata[0];
            s_d.dir_rx = host_wdata[1];
            if (host_wdata[0]) begin
                s_d.rem         = s_q.len;
                s_d.pack        = '0;
                s_d.pack_idx    = '0;
                s_d.unpack      = '0;
                s_d.unpack_left = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        host_rdata = '0;
        unique case (addr)
            A_LEN:    host_rdata = WORD_W'(s_q.len);
            A_CTRL:   host_rdata = WORD_W'({s_q.dir_rx, s_q.en});
            A_REMAIN: host_rdata = WORD_W'(s_q.rem);
            A_WORDS:  host_rdata = WORD_W'(words_sum >> IDX_W);
            A_STATUS: host_rdata = WORD_W'(status_word);
            A_FIFO:   host_rdata = (fifo_level != '0) ? fifo_head : '0;
            default:  host_rdata = '0;
        endcase
    end

    // R3: card bytes are taken only when ready and not held off
    p_take_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        card_rd_take |-> (card_rd_ready && !s_q.hold));

    // R4: a full receive FIFO stops the card side
    p_full_stalls_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flags[2*FG_FULL + 1] |-> !card_rd_take);

    // R5: each byte moved lowers the remaining count by one
    p_rem_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((card_rd_take || card_wr_valid) && !ctrl_wr)
        |=> (s_q.rem == $past(s_q.rem) - 1'b1));

    // R6: end flags follow a zero count while enabled
    p_end_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en && (s_q.rem == '0)) |=> (s_q.data_end && s_q.block_end));

    // R7: enable drops once count and level are both zero
    p_self_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en && (s_q.rem == '0) && (fifo_level == '0) && !ctrl_wr)
        |=> !s_q.en);

    // R9: a host pop arms the hold-off
    p_hold_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_pop |=> s_q.hold);

endmodule

// File: tb/card_fifo_engine_test.sv
module card_fifo_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [31:0] host_wdata = 32'd0;
    logic [31:0] host_rdata;
    logic        card_rd_ready = 1'b1;
    logic [7:0]  card_rd_data;
    logic        card_rd_take;
    logic        card_wr_valid;
    logic [7:0]  card_wr_data;

    int n_chk = 0;
    int n_fail = 0;
    int card_idx = 0;
    int wcnt = 0;
    logic [7:0] wbuf [256];

    localparam logic [2:0] AD_LEN = 3'd0, AD_CTRL = 3'd1, AD_REM = 3'd2,
        AD_WORDS = 3'd3, AD_STAT = 3'd4, AD_CLR = 3'd5, AD_FIFO = 3'd6;

    always #4 clk = ~clk;

    card_fifo_engine uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_wr       (host_wr),
        .host_rd       (host_rd),
        .host_addr     (host_addr),
        .host_wdata    (host_wdata),
        .host_rdata    (host_rdata),
        .card_rd_ready (card_rd_ready),
        .card_rd_data  (card_rd_data),
        .card_rd_take  (card_rd_take),
        .card_wr_valid (card_wr_valid),
        .card_wr_data  (card_wr_data)
    );

    function automatic logic [7:0] pattern(int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    function automatic logic [31:0] wword(int j);
        return 32'hA500_0000 ^ 32'(j * 32'h0103_0507);
    endfunction

    function automatic logic [31:0] exp_rword(int base, int j, int len);
        logic [31:0] w = 32'd0;
        for (int k = 0; k < 4; k++) begin
            if (4 * j + k < len) w = w | (32'(pattern(base + 4 * j + k)) << (8 * k));
        end
        return w;
    endfunction

    assign card_rd_data = pattern(card_idx);

    always @(posedge clk) begin
        if (!rst_n) card_idx <= 0;
        else if (card_rd_take) card_idx <= card_idx + 1;
    end

    always @(posedge clk) begin
        if (rst_n && card_wr_valid) begin
            wbuf[wcnt % 256] <= card_wr_data;
            wcnt <= wcnt + 1;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic expect_reg(string req, logic [2:0] a, logic [31:0] exp);
        logic [31:0] v;
        hread(a, v);
        chk(req, v, exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int base;
        int wbase;
        logic [31:0] v;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        #1;
        chk("R1 rd_take", 32'(card_rd_take), 32'd0);
        chk("R1 wr_valid", 32'(card_wr_valid), 32'd0);
        expect_reg("R1 status", AD_STAT, 32'd0);
        expect_reg("R1 ctrl", AD_CTRL, 32'd0);
        expect_reg("R1 remain", AD_REM, 32'd0);
        expect_reg("R11 empty fifo read", AD_FIFO, 32'd0);

        // R2 truncation, R10 word count, R8 transmit flags with empty FIFO
        hwrite(AD_LEN, 32'h0001_2345);
        expect_reg("R2 length truncated", AD_LEN, 32'h0000_2345);
        hwrite(AD_CTRL, 32'd1);
        expect_reg("R2 remain loaded", AD_REM, 32'h0000_2345);
        expect_reg("R10 word count", AD_WORDS, 32'h0000_08D2);
        expect_reg("R8 tx flags empty", AD_STAT, 32'h0000_0114);
        expect_reg("R2 ctrl readback", AD_CTRL, 32'd1);
        hwrite(AD_CTRL, 32'd0);
        expect_reg("R8 flags off when disabled", AD_STAT, 32'd0);

        // R6 zero length, R11 ignored write
        hwrite(AD_LEN, 32'd0);
        hwrite(AD_CTRL, 32'd3);
        idle(2);
        hwrite(AD_FIFO, 32'hDEAD_BEEF);
        expect_reg("R11 write ignored", AD_FIFO, 32'd0);
        expect_reg("R6 zero length ends", AD_STAT, 32'h0000_0003);
        expect_reg("R7 enable cleared dir kept", AD_CTRL, 32'd2);
        hwrite(AD_CLR, 32'd1);
        expect_reg("R6 clear data end only", AD_STAT, 32'h0000_0002);
        hwrite(AD_CLR, 32'd2);
        expect_reg("R6 clear block end", AD_STAT, 32'd0);

        // R3 ready gating
        card_rd_ready = 1'b0;
        hwrite(AD_LEN, 32'd4);
        base = card_idx;
        hwrite(AD_CTRL, 32'd3);
        idle(10);
        expect_reg("R3 no take without ready", AD_REM, 32'd4);
        card_rd_ready = 1'b1;
        idle(10);
        expect_reg("R3 taken after ready", AD_REM, 32'd0);
        expect_reg("R3 gated word", AD_FIFO, exp_rword(base, 0, 4));
        idle(3);
        expect_reg("R7 disabled after drain", AD_CTRL, 32'd2);
        hwrite(AD_CLR, 32'd3);
        expect_reg("R9 status read releases", AD_STAT, 32'd0);

        // R3 packing sweep over lengths
        for (int len = 1; len <= 9; len++) begin
            hwrite(AD_LEN, 32'(len));
            base = card_idx;
            hwrite(AD_CTRL, 32'd3);
            idle(20);
            expect_reg("R3 remain zero", AD_REM, 32'd0);
            expect_reg("R10 word count zero", AD_WORDS, 32'd0);
            for (int j = 0; j < (len + 3) / 4; j++) begin
                expect_reg("R3 packed word", AD_FIFO, exp_rword(base, j, len));
            end
            idle(3);
            expect_reg("R7 rx self clear", AD_CTRL, 32'd2);
            expect_reg("R6 end flags rx", AD_STAT, 32'h0000_0003);
            hwrite(AD_CLR, 32'd3);
            expect_reg("R6 cleared", AD_STAT, 32'd0);
        end

        // R4 fill, R8 receive flags, R9 hold-off, R10 count
        hwrite(AD_LEN, 32'd80);
        base = card_idx;
        hwrite(AD_CTRL, 32'd3);
        idle(100);
        expect_reg("R4 stops when full", AD_REM, 32'd16);
        expect_reg("R8 rx flags full", AD_STAT, 32'h0000_08A8);
        expect_reg("R4 first word", AD_FIFO, exp_rword(base, 0, 80));
        idle(20);
        expect_reg("R9 held after pop", AD_REM, 32'd16);
        expect_reg("R10 words", AD_WORDS, 32'd4);
        idle(20);
        expect_reg("R9 resumed", AD_REM, 32'd12);
        for (int j = 1; j < 20; j++) begin
            expect_reg("R4 drained word", AD_FIFO, exp_rword(base, j, 80));
            hread(AD_STAT, v);
            idle(8);
        end
        idle(3);
        expect_reg("R6 long rx end", AD_STAT, 32'h0000_0003);
        hwrite(AD_CLR, 32'd3);
        hread(AD_STAT, v);

        // R5 unpacking sweep
        for (int len = 1; len <= 9; len++) begin
            hwrite(AD_LEN, 32'(len));
            wbase = wcnt;
            hwrite(AD_CTRL, 32'd1);
            for (int j = 0; j < (len + 3) / 4; j++) hwrite(AD_FIFO, wword(j));
            idle(30);
            chk("R5 byte count", 32'(wcnt - wbase), 32'(len));
            for (int b = 0; b < len; b++) begin
                chk("R5 byte value", 32'(wbuf[(wbase + b) % 256]),
                    32'(8'(wword(b / 4) >> (8 * (b % 4)))));
            end
            expect_reg("R5 remain zero", AD_REM, 32'd0);
            expect_reg("R7 tx self clear", AD_CTRL, 32'd0);
            expect_reg("R6 end flags tx", AD_STAT, 32'h0000_0003);
            hwrite(AD_CLR, 32'd3);
        end

        // R12 overflow by a back-to-back burst
        hwrite(AD_LEN, 32'd80);
        wbase = wcnt;
        hwrite(AD_CTRL, 32'd1);
        @(negedge clk);
        host_wr = 1'b1; host_addr = AD_FIFO;
        for (int j = 0; j < 20; j++) begin
            host_wdata = wword(j);
            @(negedge clk);
        end
        host_wr = 1'b0;
        idle(100);
        chk("R12 bytes sent", 32'(wcnt - wbase), 32'd64);
        for (int b = 0; b < 64; b++) begin
            chk("R12 kept words", 32'(wbuf[(wbase + b) % 256]),
                32'(8'(wword(b / 4) >> (8 * (b % 4)))));
        end
        expect_reg("R12 remain", AD_REM, 32'd16);
        expect_reg("R8 tx flags starved", AD_STAT, 32'h0000_0114);
        hwrite(AD_CTRL, 32'd0);
        expect_reg("R11 empty read after stop", AD_FIFO, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule